// File: doc/BRIEF.md
# Flash Command Write Sequencer

This block sits between a processor's register bus and an abstract embedded-flash back end. Software stages a program or erase operation in three strictly ordered steps. First it writes a data word to the target flash address. Next it writes an operation code to a buffered command register. Last it writes 1 to the buffer-empty status bit, which launches the operation. The sequencer checks every step as it arrives. Any step out of order, an unknown code, an address inside the protected range, or a launch before the clock divider has been programmed abandons the sequence. In each of these cases nothing is sent to the back end, and a sticky error flag is raised instead.

Launched operations pass through two slots: one pending and one active. A second operation can be staged and launched while the first is still running. The back end receives a start strobe with the operation, the address and the data, and answers with a one-cycle done pulse. The pending operation is started in the cycle after that done pulse. A clock divider register, with a bit that shows it has been loaded, and a protection boundary register complete the register set.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, the status register (register select 1) reads bit0 buffer-empty = 1, bit1 command-complete = 1, bit2 access-error = 0 and bit3 protection-violation = 0. The divider register (select 0) reads 0, and its loaded indicator is bit 15.
- R2: Any write to the divider register stores the divider in bits 7:0 and sets bit 15. A later rewrite changes the value and leaves bit 15 set.
- R3: A launch arriving while the divider has never been written sets access-error, and no start strobe is issued.
- R4: The ordered sequence is a flash write, then a write to the command register (select 2) of code 0x20 (word program), 0x40 (page erase) or 0x41 (mass erase), then a write to the status register with bit0 = 1. This sequence issues exactly one single-cycle start strobe carrying the code, the address and the data. Command-complete reads 0 once the operation has been launched.
- R5: Any write between the steps, or a command-register write or launch without the earlier steps, abandons the sequence and sets access-error.
- R6: A command code outside the three supported ones sets access-error and abandons the sequence.
- R7: When the protection boundary register (select 3) holds B, a program or page erase aimed at an address below B sets protection-violation and abandons the sequence. A mass erase with B ≠ 0 does the same.
- R8: While either error flag is set, a flash write starts no sequence and sets access-error. Writing 1 to status bit2 or bit3 clears that flag. Writing 0 to those bits leaves the flags unchanged.
- R9: Buffer-empty reads 0 while a launched operation waits in the pending slot. A flash write in that state sets access-error.
- R10: Command-complete reads 1 only when both the active slot and the pending slot are empty.
- R11: A pending operation is started in the cycle immediately after the back end reports done for the active one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fl_we | input | 1 | Flash array write strobe (sequence step one) |
| fl_addr | input | AW | Flash word address |
| fl_wdata | input | DW | Flash write data |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 divider, 1 status, 2 command, 3 protection boundary |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data of the selected register |
| be_start | output | 1 | Single-cycle start strobe to the back end |
| be_cmd | output | 8 | Operation code of the started operation |
| be_addr | output | AW | Address of the started operation |
| be_data | output | DW | Data of the started operation |
| be_done | input | 1 | Back end done pulse for the active operation |

## Verification
The two functions that can fall in the same cycle are a software launch and the back end's done pulse for the active operation. On that edge the new operation must enter the pending slot while the active slot empties, and the following cycle must start it. A back-end model with a one-cycle latency is driven against a burst of back-to-back sequences, so that launches and done pulses coincide on the same edge. A behavioural model built from queues in the bench predicts the start strobe, its payload and the status bits, and these are compared with the design on every clock.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
   typedef enum logic [1:0] {SEQ_IDLE, SEQ_HAVE_DATA, SEQ_ARMED} seq_state_t;

   localparam logic [1:0] RSEL_DIV  = 2'd0;
   localparam logic [1:0] RSEL_STAT = 2'd1;
   localparam logic [1:0] RSEL_CMD  = 2'd2;
   localparam logic [1:0] RSEL_PROT = 2'd3;

   localparam int ST_EMPTY = 0;
   localparam int ST_DONE  = 1;
   localparam int ST_ACC   = 2;
   localparam int ST_PROT  = 3;

   localparam int CW = 8;
   localparam logic [CW-1:0] OP_PROG   = 8'h20;
   localparam logic [CW-1:0] OP_PERASE = 8'h40;
   localparam logic [CW-1:0] OP_MERASE = 8'h41;

   function automatic logic op_known(input logic [CW-1:0] op);
      return (op == OP_PROG) || (op == OP_PERASE) || (op == OP_MERASE);
   endfunction
endpackage

// File: rtl/fcs_regs.sv
module fcs_regs
   import fcs_pkg::*;
#(
   parameter int AW   = 12,
   parameter int DW   = 16,
   parameter int DIVW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [1:0]      sel,
   input  logic [DW-1:0]   wdata,
   output logic [DIVW-1:0] div_val,
   output logic            div_loaded,
   output logic [AW-1:0]   prot_bound
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_val    <= '0;
         div_loaded <= 1'b0;
         prot_bound <= '0;
      end else if (we) begin
         if (sel == RSEL_DIV) begin
            div_val    <= wdata[DIVW-1:0];
            div_loaded <= 1'b1;
         end
         if (sel == RSEL_PROT) prot_bound <= wdata[AW-1:0];
      end
   end

   // R2
   loaded_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_loaded |=> div_loaded);
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
   import fcs_pkg::*;
#(
   parameter int AW       = 12,
   parameter int DW       = 16,
   parameter bit PROT_LOW = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fl_we,
   input  logic [AW-1:0] fl_addr,
   input  logic [DW-1:0] fl_wdata,
   input  logic          reg_we,
   input  logic [1:0]    reg_sel,
   input  logic [DW-1:0] reg_wdata,
   input  logic          buf_empty,
   input  logic          div_loaded,
   input  logic [AW-1:0] prot_bound,
   output logic          launch,
   output logic [CW-1:0] l_cmd,
   output logic [AW-1:0] l_addr,
   output logic [DW-1:0] l_data,
   output logic          acc_err,
   output logic          prot_viol
);
   seq_state_t    st, st_nxt;
   logic          acc_set, pv_set, cap_data, cap_cmd;
   logic          in_prot, op_viol, is_launch, clr_acc, clr_pv;
   logic [CW-1:0] op_in;

   assign op_in     = reg_wdata[CW-1:0];
   assign is_launch = reg_we && (reg_sel == RSEL_STAT) && reg_wdata[ST_EMPTY];
   assign clr_acc   = reg_we && (reg_sel == RSEL_STAT) && reg_wdata[ST_ACC];
   assign clr_pv    = reg_we && (reg_sel == RSEL_STAT) && reg_wdata[ST_PROT];

   generate
      if (PROT_LOW) begin : g_prot_low
         assign in_prot = l_addr < prot_bound;
      end else begin : g_prot_high
         assign in_prot = (prot_bound != '0) && (l_addr >= prot_bound);
      end
   endgenerate

   assign op_viol = (op_in == OP_MERASE) ? (prot_bound != '0) : in_prot;

   always_comb begin
      st_nxt   = st;
      acc_set  = 1'b0;
      pv_set   = 1'b0;
      cap_data = 1'b0;
      cap_cmd  = 1'b0;
      launch   = 1'b0;
      unique case (st)
         SEQ_IDLE: begin
            if (fl_we) begin
               if (acc_err || prot_viol || !buf_empty) acc_set = 1'b1;
               else begin
                  cap_data = 1'b1;
                  st_nxt   = SEQ_HAVE_DATA;
               end
            end else if (reg_we && ((reg_sel == RSEL_CMD) || is_launch)) begin
               acc_set = 1'b1;
            end
         end
         SEQ_HAVE_DATA: begin
            if (reg_we && (reg_sel == RSEL_CMD) && !fl_we) begin
               st_nxt = SEQ_IDLE;
               if (!op_known(op_in)) acc_set = 1'b1;
               else if (op_viol)     pv_set  = 1'b1;
               else begin
                  cap_cmd = 1'b1;
                  st_nxt  = SEQ_ARMED;
               end
            end else if (fl_we || reg_we) begin
               acc_set = 1'b1;
               st_nxt  = SEQ_IDLE;
            end
         end
         SEQ_ARMED: begin
            if (is_launch && !fl_we) begin
               st_nxt = SEQ_IDLE;
               if (!div_loaded) acc_set = 1'b1;
               else             launch  = 1'b1;
            end else if (fl_we || reg_we) begin
               acc_set = 1'b1;
               st_nxt  = SEQ_IDLE;
            end
         end
         default: st_nxt = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= SEQ_IDLE;
         acc_err   <= 1'b0;
         prot_viol <= 1'b0;
         l_cmd     <= '0;
         l_addr    <= '0;
         l_data    <= '0;
      end else begin
         st        <= st_nxt;
         acc_err   <= (acc_err & ~clr_acc) | acc_set;
         prot_viol <= (prot_viol & ~clr_pv) | pv_set;
         if (cap_data) begin
            l_addr <= fl_addr;
            l_data <= fl_wdata;
         end
         if (cap_cmd) l_cmd <= op_in;
      end
   end

   // R3
   launch_needs_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> div_loaded);

   // R8
   no_start_with_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SEQ_IDLE && fl_we && (acc_err || prot_viol)) |=> (st == SEQ_IDLE && acc_err));

   // R6
   unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SEQ_HAVE_DATA && reg_we && reg_sel == RSEL_CMD && !fl_we && !op_known(op_in))
         |=> (acc_err && st == SEQ_IDLE));
endmodule

// File: rtl/fcs_queue.sv
module fcs_queue
   import fcs_pkg::*;
#(
   parameter int AW = 12,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic [CW-1:0] l_cmd,
   input  logic [AW-1:0] l_addr,
   input  logic [DW-1:0] l_data,
   input  logic          be_done,
   output logic          be_start,
   output logic [CW-1:0] be_cmd,
   output logic [AW-1:0] be_addr,
   output logic [DW-1:0] be_data,
   output logic          buf_empty,
   output logic          cmd_done
);
   logic pend_v, act_v;

   assign be_start  = pend_v && !act_v;
   assign buf_empty = !pend_v;
   assign cmd_done  = !pend_v && !act_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v  <= 1'b0;
         act_v   <= 1'b0;
         be_cmd  <= '0;
         be_addr <= '0;
         be_data <= '0;
      end else begin
         if (launch) begin
            pend_v  <= 1'b1;
            be_cmd  <= l_cmd;
            be_addr <= l_addr;
            be_data <= l_data;
         end else if (be_start) begin
            pend_v <= 1'b0;
         end
         if (be_start)     act_v <= 1'b1;
         else if (be_done) act_v <= 1'b0;
      end
   end

   // R11
   pend_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (be_done && pend_v) |=> be_start);

   // R9
   launch_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> buf_empty);

   // R4
   single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      be_start |=> !be_start);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import fcs_pkg::*;
#(
   parameter int AW       = 12,
   parameter int DW       = 16,
   parameter int DIVW     = 8,
   parameter bit PROT_LOW = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fl_we,
   input  logic [AW-1:0] fl_addr,
   input  logic [DW-1:0] fl_wdata,
   input  logic          reg_we,
   input  logic [1:0]    reg_sel,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          be_start,
   output logic [7:0]    be_cmd,
   output logic [AW-1:0] be_addr,
   output logic [DW-1:0] be_data,
   input  logic          be_done
);
   localparam int LOADED_BIT = DW - 1;

   generate
      if (DW < CW || DW < 4) begin : g_bad_dw
         $error("DW too narrow for command and status fields");
      end
      if (DIVW >= DW) begin : g_bad_divw
         $error("DIVW must leave room for the loaded bit");
      end
      if (AW > DW) begin : g_bad_aw
         $error("AW must fit in a register word");
      end
   endgenerate

   logic [DIVW-1:0] div_val;
   logic            div_loaded;
   logic [AW-1:0]   prot_bound;
   logic            launch, acc_err, prot_viol, buf_empty, cmd_done;
   logic [CW-1:0]   l_cmd;
   logic [AW-1:0]   l_addr;
   logic [DW-1:0]   l_data;

   fcs_regs #(.AW(AW), .DW(DW), .DIVW(DIVW)) i_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
      .div_val(div_val), .div_loaded(div_loaded), .prot_bound(prot_bound)
   );

   fcs_seq #(.AW(AW), .DW(DW), .PROT_LOW(PROT_LOW)) i_seq (
      .clk(clk), .rst_n(rst_n), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .buf_empty(buf_empty), .div_loaded(div_loaded), .prot_bound(prot_bound),
      .launch(launch), .l_cmd(l_cmd), .l_addr(l_addr), .l_data(l_data),
      .acc_err(acc_err), .prot_viol(prot_viol)
   );

   fcs_queue #(.AW(AW), .DW(DW)) i_queue (
      .clk(clk), .rst_n(rst_n), .launch(launch), .l_cmd(l_cmd), .l_addr(l_addr),
      .l_data(l_data), .be_done(be_done), .be_start(be_start), .be_cmd(be_cmd),
      .be_addr(be_addr), .be_data(be_data), .buf_empty(buf_empty), .cmd_done(cmd_done)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (reg_sel)
         RSEL_DIV: begin
            reg_rdata[DIVW-1:0]  = div_val;
            reg_rdata[LOADED_BIT] = div_loaded;
         end
         RSEL_STAT: begin
            reg_rdata[ST_EMPTY] = buf_empty;
            reg_rdata[ST_DONE]  = cmd_done;
            reg_rdata[ST_ACC]   = acc_err;
            reg_rdata[ST_PROT]  = prot_viol;
         end
         RSEL_CMD:  reg_rdata[CW-1:0] = l_cmd;
         default:   reg_rdata[AW-1:0] = prot_bound;
      endcase
   end

   // R10
   done_implies_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      be_start |=> !cmd_done);
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
   localparam int AW = 12;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fl_we = 1'b0;
   logic [AW-1:0] fl_addr = '0;
   logic [DW-1:0] fl_wdata = '0;
   logic          reg_we = 1'b0;
   logic [1:0]    reg_sel = 2'd1;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          be_start;
   logic [7:0]    be_cmd;
   logic [AW-1:0] be_addr;
   logic [DW-1:0] be_data;
   logic          be_done = 1'b0;

   int errors = 0;
   int checks = 0;
   int nstart = 0;
   int lat = 5;
   int cnt = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   flash_cmd_seq i_flash_cmd_seq (
      .clk(clk), .rst_n(rst_n), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
      .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .be_start(be_start), .be_cmd(be_cmd), .be_addr(be_addr), .be_data(be_data),
      .be_done(be_done)
   );

   // behavioural reference model
   int          m_st = 0;
   bit          m_acc = 0, m_pv = 0, m_loaded = 0, m_act = 0;
   logic [11:0] m_bound = '0, m_addr = '0;
   logic [15:0] m_data = '0;
   logic [7:0]  m_cmd = '0;
   logic [35:0] q[$];
   bit          e_start = 0;
   logic [35:0] e_pay = '0;

   function automatic bit known(input logic [7:0] c);
      return c == 8'h20 || c == 8'h40 || c == 8'h41;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_acc = 0; m_pv = 0; m_loaded = 0; m_act = 0;
         m_bound = '0; q.delete();
      end else begin
         bit pre_empty, pre_start, aset, pset, lnch, viol;
         pre_empty = (q.size() == 0);
         pre_start = (q.size() != 0) && !m_act;
         aset = 0; pset = 0;
         lnch = reg_we && reg_sel == 2'd1 && reg_wdata[0];
         if (pre_start) begin
            void'(q.pop_front());
            m_act = 1;
         end else if (be_done) m_act = 0;
         case (m_st)
            0: begin
               if (fl_we) begin
                  if (m_acc || m_pv || !pre_empty) aset = 1;
                  else begin m_addr = fl_addr; m_data = fl_wdata; m_st = 1; end
               end else if (reg_we && (reg_sel == 2'd2 || lnch)) aset = 1;
            end
            1: begin
               if (reg_we && reg_sel == 2'd2 && !fl_we) begin
                  m_st = 0;
                  viol = (reg_wdata[7:0] == 8'h41) ? (m_bound != 0) : (m_addr < m_bound);
                  if (!known(reg_wdata[7:0])) aset = 1;
                  else if (viol) pset = 1;
                  else begin m_cmd = reg_wdata[7:0]; m_st = 2; end
               end else if (fl_we || reg_we) begin aset = 1; m_st = 0; end
            end
            default: begin
               if (lnch && !fl_we) begin
                  m_st = 0;
                  if (!m_loaded) aset = 1;
                  else q.push_back({m_cmd, m_addr, m_data});
               end else if (fl_we || reg_we) begin aset = 1; m_st = 0; end
            end
         endcase
         if (reg_we && reg_sel == 2'd1) begin
            if (reg_wdata[2]) m_acc = 0;
            if (reg_wdata[3]) m_pv = 0;
         end
         if (aset) m_acc = 1;
         if (pset) m_pv = 1;
         if (reg_we && reg_sel == 2'd0) m_loaded = 1;
         if (reg_we && reg_sel == 2'd3) m_bound = reg_wdata[11:0];
      end
      e_start = (q.size() != 0) && !m_act;
      e_pay   = (q.size() != 0) ? q[0] : '0;
   end

   task automatic fail(input string r, input int got, input int exp);
      errors++;
      $display("FAIL %s: got %0h expected %0h", r, got, exp);
   endtask

   // per-clock compare and back-end stub
   always @(negedge clk) begin
      if (rst_n) begin
         logic [3:0] es;
         checks++;
         if (be_start !== e_start) fail("R4/R11 start", be_start, e_start);
         else if (e_start && {be_cmd, be_addr, be_data} !== e_pay)
            fail("R4 payload", {be_cmd, be_addr, be_data}, e_pay);
         if (!reg_we && reg_sel == 2'd1) begin
            es = {m_pv, m_acc, (q.size() == 0) && !m_act, q.size() == 0};
            checks++;
            if (reg_rdata[3:0] !== es) fail("R8/R9/R10 status", reg_rdata[3:0], es);
         end
         if (be_start) nstart++;
         if (be_done) be_done <= 1'b0;
         if (cnt > 0) begin
            cnt--;
            if (cnt == 0) be_done <= 1'b1;
         end
         if (be_start) cnt = lat;
      end
      cyc++;
      if (cyc > 100000) begin
         errors++;
         $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic fw(input logic [11:0] a, input logic [15:0] d);
      @(posedge clk); #1;
      fl_we = 1; fl_addr = a; fl_wdata = d;
      @(posedge clk); #1;
      fl_we = 0;
   endtask

   task automatic rw(input logic [1:0] s, input logic [15:0] d);
      @(posedge clk); #1;
      reg_we = 1; reg_sel = s; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 0; reg_sel = 2'd1;
   endtask

   task automatic chk(input string r, input int got, input int exp);
      checks++;
      if (got != exp) fail(r, got, exp);
   endtask

   task automatic stat(input string r, input logic [3:0] mask, input logic [3:0] exp);
      @(negedge clk);
      chk(r, int'(reg_rdata[3:0] & mask), int'(exp));
   endtask

   task automatic rd(input string r, input logic [1:0] s, input logic [15:0] exp);
      @(posedge clk); #1;
      reg_sel = s;
      @(negedge clk);
      chk(r, int'(reg_rdata), int'(exp));
      @(posedge clk); #1;
      reg_sel = 2'd1;
   endtask

   task automatic seq3(input logic [11:0] a, input logic [15:0] d, input logic [7:0] c);
      fw(a, d); rw(2'd2, {8'h0, c}); rw(2'd1, 16'h1);
   endtask

   task automatic clr();
      rw(2'd1, 16'h000C);
   endtask

   initial begin
      int n0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      stat("R1 status", 4'hF, 4'h3);
      rd("R1 divider", 2'd0, 16'h0000);
      // R3 launch with divider never loaded
      seq3(12'h100, 16'hABCD, 8'h20);
      stat("R3 acc", 4'h4, 4'h4);
      chk("R3 no start", nstart, 0);
      rw(2'd1, 16'h0000);
      stat("R8 write 0 keeps", 4'h4, 4'h4);
      clr();
      stat("R8 clear", 4'hC, 4'h0);
      // R2 divider
      rw(2'd0, 16'h0013);
      rd("R2 load", 2'd0, 16'h8013);
      rw(2'd0, 16'h0005);
      rd("R2 rewrite", 2'd0, 16'h8005);
      // R4 good program
      seq3(12'h100, 16'h1234, 8'h20);
      @(negedge clk);
      chk("R4 start", be_start, 1);
      chk("R4 addr", be_addr, 12'h100);
      chk("R4 data", be_data, 16'h1234);
      chk("R4 cmd", be_cmd, 8'h20);
      chk("R4 busy", reg_rdata[1], 0);
      repeat (10) @(posedge clk);
      stat("R10 idle", 4'h3, 4'h3);
      // R5 ordering
      n0 = nstart;
      rw(2'd2, 16'h20);
      stat("R5 cmd first", 4'h4, 4'h4); clr();
      fw(12'h200, 16'h1); fw(12'h201, 16'h2);
      stat("R5 double data", 4'h4, 4'h4); clr();
      fw(12'h200, 16'h1); rw(2'd2, 16'h20); rw(2'd0, 16'h5);
      stat("R5 intervening", 4'h4, 4'h4); clr();
      rw(2'd1, 16'h1);
      stat("R5 bare launch", 4'h4, 4'h4); clr();
      // R6 unknown code
      fw(12'h200, 16'h1); rw(2'd2, 16'h7F);
      stat("R6 unknown", 4'hC, 4'h4); clr();
      repeat (3) @(posedge clk);
      chk("R5 no start", nstart, n0);
      // R7 protection
      rw(2'd3, 16'h0080);
      fw(12'h040, 16'h9); rw(2'd2, 16'h20);
      stat("R7 prog viol", 4'hC, 4'h8);
      fw(12'h200, 16'h1);
      stat("R8 blocked", 4'hC, 4'hC);
      clr();
      fw(12'h200, 16'h1); rw(2'd2, 16'h41);
      stat("R7 mass viol", 4'hC, 4'h8); clr();
      seq3(12'h200, 16'h0, 8'h40);
      repeat (3) @(posedge clk);
      chk("R7 allowed start", nstart, n0 + 1);
      repeat (10) @(posedge clk);
      rw(2'd3, 16'h0000);
      // R9 R10 R11 double buffering
      lat = 20;
      seq3(12'h300, 16'hAAAA, 8'h20);
      repeat (2) @(posedge clk);
      seq3(12'h400, 16'hBBBB, 8'h40);
      stat("R9 pending full", 4'h3, 4'h0);
      fw(12'h500, 16'h1);
      stat("R9 full write", 4'h4, 4'h4); clr();
      for (int i = 0; i < 100 && !be_done; i++) @(posedge clk);
      @(negedge clk);
      chk("R11 start after done", be_start, 1);
      chk("R11 addr", be_addr, 12'h400);
      stat("R10 second busy", 4'h3, 4'h1);
      repeat (30) @(posedge clk);
      stat("R10 both done", 4'h3, 4'h3);
      // launch coinciding with done
      lat = 1;
      for (int k = 0; k < 6; k++) seq3(12'h600 + k[11:0], 16'h100 + k[15:0], 8'h20);
      repeat (10) @(posedge clk);
      stat("R10 burst done", 4'h3, 4'h3);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule